// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter with Alarm

This block holds the wall-clock time and the calendar date as packed decimal digits. Each pulse on a one-per-second enable advances the seconds. Carries then ripple through minutes, hours, day, month and a two-digit year. A three-bit day-of-week code steps once at every midnight rollover. Month lengths, including February in leap years, are computed from the current month and year. Hours run on either a 24-hour scale or a 12-hour scale with an afternoon flag, chosen by one input.

A register bus can load the time word, the date word, the weekday code and the two alarm words. Each is loaded with its own strobe from a shared data input. The block compares the running time and date with the alarm words. It gives a single-cycle pulse when both become equal, for use by a separate interrupt block. It also shows whether the current year is a leap year.

Top module: `bcd_clock_cal`

## Requirements
- R1: The time word packs seconds units in bits 3:0 and tens in 6:4, minutes units in 11:8 and tens in 14:12, and hour digits from bit 16 up. A clock cycle with `secTick` high and no time load adds one second, and units carry into tens at 9. Seconds and minutes tens wrap 5 to 0, so 59 goes to 00 and carries on.
- R2: With `hourMode12` low, hours use units in bits 19:16 and tens in 21:20 and run 00 to 23. One tick at 23:59:59 gives 00:00:00 and is a midnight rollover.
- R3: With `hourMode12` high, hours run 1 to 12. The hour tens sits in bit 20 and bit 21 is the afternoon flag (1 = PM). A tick at 11:59:59 gives 12:00:00 and flips the flag. A tick at 12:59:59 gives 01:00:00 and keeps the flag. A tick at 11:59:59 PM gives 12:00:00 AM (0x120000) and is a midnight rollover.
- R4: The date word packs day units in bits 3:0 and tens in 5:4, month units in 11:8 and tens in bit 12, and year units in 19:16 and tens in 23:20. At a midnight rollover the day steps. After day 30 in months 4, 6, 9 and 11, or after day 31 in the other months except February, the day goes back to 01 and the month steps.
- R5: `leapYear` is 1 when the two-digit year value is a multiple of 4. February then ends after day 29; otherwise it ends after day 28.
- R6: `dowOut` is a code with 0 for Sunday through 6 for Saturday. It steps by one at each midnight rollover, and 6 (or the unused code 7) wraps to 0.
- R7: A month step from 12 gives month 01 and steps the year. Year 99 goes to 00.
- R8: `alarmHit` is high for exactly one cycle when the time word and date word both become equal to the alarm time and alarm date words. A time match with a different date gives no pulse.
- R9: `ldTime`, `ldDate` and `ldDow` load `wrData`, masked to the used bits (time 0x3F7F7F, date 0xFF1F3F, weekday bits 2:0), on the next clock edge. A time load in a tick cycle drops that tick completely. A date or weekday load at a midnight rollover replaces that field's increment, while the other fields still advance.
- R10: After reset the time is 00:00:00, the date is 0x000101, the weekday is 0, `leapYear` is 1 and `alarmHit` is 0. Without a tick or a load, time, date and weekday hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| secTick | input | 1 | One-second advance enable |
| hourMode12 | input | 1 | 1 = 12-hour scale, 0 = 24-hour scale |
| ldTime | input | 1 | Load time word from wrData |
| ldDate | input | 1 | Load date word from wrData |
| ldDow | input | 1 | Load weekday code from wrData |
| ldAlmTime | input | 1 | Load alarm time word from wrData |
| ldAlmDate | input | 1 | Load alarm date word from wrData |
| wrData | input | 24 | Bus write data |
| timeOut | output | 22 | Current packed time |
| dateOut | output | 24 | Current packed date |
| dowOut | output | 3 | Current weekday code |
| leapYear | output | 1 | Current year is a leap year |
| alarmHit | output | 1 | One-cycle alarm match pulse |

## Verification
The risky overlap is a bus load arriving in the same cycle as a tick that would carry. Examples are a date or weekday load at the 23:59:59 tick, or a time load on any tick. The bench forces these overlaps on purpose and compares every field against its behavioural model. That model advances a seconds-of-day integer and a day/month/year triple, so the block must drop or keep each carry exactly as R9 states. Alarm pulses that fall on the same edge as a midnight rollover are also judged cycle by cycle against that model.

// File: rtl/bcd_clk_pkg.sv
package bcd_clk_pkg;
  localparam int TIME_W = 22;
  localparam int DATE_W = 24;
  localparam int DOW_W  = 3;
  localparam logic [TIME_W-1:0] TIME_MASK = 22'h3F7F7F;
  localparam logic [DATE_W-1:0] DATE_MASK = 24'hFF1F3F;
  localparam logic [DATE_W-1:0] DATE_RST  = 24'h000101;
  localparam logic [DOW_W-1:0]  DOW_LAST  = 3'd6;

  typedef struct packed {
    logic stepSec;
    logic stepMin;
    logic stepHr;
    logic stepDay;
    logic stepMon;
    logic stepYr;
    logic stepDow;
    logic ldTime;
    logic ldDate;
    logic ldDow;
    logic ldAlmTime;
    logic ldAlmDate;
  } strobe_t;

  typedef struct packed {
    logic secMax;
    logic minMax;
    logic hrWrap;
    logic dayLast;
    logic monLast;
    logic match;
  } flag_t;

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [6:0] bcdToBin(input logic [7:0] v);
    return ({3'b000, v[7:4]} * 7'd10) + {3'b000, v[3:0]};
  endfunction
endpackage

// File: rtl/bcd_clk_ctrl.sv
module bcd_clk_ctrl
  import bcd_clk_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    secTick,
  input  logic    ldTime,
  input  logic    ldDate,
  input  logic    ldDow,
  input  logic    ldAlmTime,
  input  logic    ldAlmDate,
  input  flag_t   flags,
  output strobe_t strb,
  output logic    alarmHit
);
  logic matchPrev;
  logic midnight;

  always_comb begin
    strb           = '0;
    strb.ldTime    = ldTime;
    strb.ldDate    = ldDate;
    strb.ldDow     = ldDow;
    strb.ldAlmTime = ldAlmTime;
    strb.ldAlmDate = ldAlmDate;
    strb.stepSec   = secTick & ~ldTime;
    strb.stepMin   = strb.stepSec & flags.secMax;
    strb.stepHr    = strb.stepMin & flags.minMax;
    midnight       = strb.stepHr & flags.hrWrap;
    strb.stepDay   = midnight & ~ldDate;
    strb.stepDow   = midnight & ~ldDow;
    strb.stepMon   = strb.stepDay & flags.dayLast;
    strb.stepYr    = strb.stepMon & flags.monLast;
  end

  always_ff @(posedge clk) begin
    if (!rstN) matchPrev <= 1'b0;
    else       matchPrev <= flags.match;
  end

  assign alarmHit = flags.match & ~matchPrev;
endmodule

// File: rtl/bcd_clk_datapath.sv
module bcd_clk_datapath
  import bcd_clk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              mode12,
  input  logic [DATE_W-1:0] wrData,
  input  strobe_t           strb,
  output flag_t             flags,
  output logic [TIME_W-1:0] timeQ,
  output logic [DATE_W-1:0] dateQ,
  output logic [DOW_W-1:0]  dowQ,
  output logic              leap
);
  logic [TIME_W-1:0] almTimeQ;
  logic [DATE_W-1:0] almDateQ;
  logic [7:0] secB, minB, dayB, monB, yrB;
  logic [7:0] secN, minN, dayN, monN, yrN;
  logic [5:0] hrN;
  logic [3:0] hrU;
  logic [6:0] dayBin, monBin, lastDay;

  assign secB   = {1'b0, timeQ[6:4], timeQ[3:0]};
  assign minB   = {1'b0, timeQ[14:12], timeQ[11:8]};
  assign hrU    = timeQ[19:16];
  assign dayB   = {2'b00, dateQ[5:4], dateQ[3:0]};
  assign monB   = {3'b000, dateQ[12], dateQ[11:8]};
  assign yrB    = dateQ[23:16];
  assign dayBin = bcdToBin(dayB);
  assign monBin = bcdToBin(monB);

  assign leap = yrB[4] ? (yrB[3:0] == 4'd2 || yrB[3:0] == 4'd6)
                       : (yrB[3:0] == 4'd0 || yrB[3:0] == 4'd4 || yrB[3:0] == 4'd8);

  always_comb begin
    case (monBin)
      7'd2:                            lastDay = leap ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:         lastDay = 7'd30;
      default:                         lastDay = 7'd31;
    endcase
  end

  always_comb begin
    flags.secMax  = (secB == 8'h59);
    flags.minMax  = (minB == 8'h59);
    flags.hrWrap  = mode12 ? (timeQ[21] && timeQ[20] && hrU == 4'd1)
                           : (timeQ[21:20] == 2'd2 && hrU == 4'd3);
    flags.dayLast = (dayBin >= lastDay);
    flags.monLast = (monBin >= 7'd12);
    flags.match   = (timeQ == almTimeQ) && (dateQ == almDateQ);
  end

  assign secN = flags.secMax ? 8'h00 : bcdInc(secB);
  assign minN = flags.minMax ? 8'h00 : bcdInc(minB);
  assign dayN = flags.dayLast ? 8'h01 : bcdInc(dayB);
  assign monN = flags.monLast ? 8'h01 : bcdInc(monB);
  assign yrN  = (yrB == 8'h99) ? 8'h00 : bcdInc(yrB);

  always_comb begin
    if (mode12) begin
      if (timeQ[20] && hrU == 4'd2)       hrN = {timeQ[21], 1'b0, 4'd1};
      else if (timeQ[20] && hrU == 4'd1)  hrN = {~timeQ[21], 1'b1, 4'd2};
      else if (!timeQ[20] && hrU == 4'd9) hrN = {timeQ[21], 1'b1, 4'd0};
      else                                hrN = {timeQ[21], timeQ[20], hrU + 4'd1};
    end else begin
      if (flags.hrWrap)      hrN = 6'd0;
      else if (hrU == 4'd9)  hrN = {timeQ[21:20] + 2'd1, 4'd0};
      else                   hrN = {timeQ[21:20], hrU + 4'd1};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timeQ <= '0;
    end else if (strb.ldTime) begin
      timeQ <= wrData[TIME_W-1:0] & TIME_MASK;
    end else begin
      if (strb.stepSec) timeQ[7:0]   <= secN & 8'h7F;
      if (strb.stepMin) timeQ[15:8]  <= minN & 8'h7F;
      if (strb.stepHr)  timeQ[21:16] <= hrN;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dateQ <= DATE_RST;
    end else if (strb.ldDate) begin
      dateQ <= wrData & DATE_MASK;
    end else begin
      if (strb.stepDay) dateQ[7:0]   <= dayN & 8'h3F;
      if (strb.stepMon) dateQ[15:8]  <= monN & 8'h1F;
      if (strb.stepYr)  dateQ[23:16] <= yrN;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             dowQ <= '0;
    else if (strb.ldDow)   dowQ <= wrData[DOW_W-1:0];
    else if (strb.stepDow) dowQ <= (dowQ >= DOW_LAST) ? '0 : dowQ + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      almTimeQ <= '0;
      almDateQ <= '0;
    end else begin
      if (strb.ldAlmTime) almTimeQ <= wrData[TIME_W-1:0] & TIME_MASK;
      if (strb.ldAlmDate) almDateQ <= wrData & DATE_MASK;
    end
  end
endmodule

// File: rtl/bcd_clock_cal.sv
module bcd_clock_cal
  import bcd_clk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic              hourMode12,
  input  logic              ldTime,
  input  logic              ldDate,
  input  logic              ldDow,
  input  logic              ldAlmTime,
  input  logic              ldAlmDate,
  input  logic [DATE_W-1:0] wrData,
  output logic [TIME_W-1:0] timeOut,
  output logic [DATE_W-1:0] dateOut,
  output logic [DOW_W-1:0]  dowOut,
  output logic              leapYear,
  output logic              alarmHit
);
  strobe_t strb;
  flag_t   flags;

  bcd_clk_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .secTick(secTick),
    .ldTime(ldTime), .ldDate(ldDate), .ldDow(ldDow),
    .ldAlmTime(ldAlmTime), .ldAlmDate(ldAlmDate),
    .flags(flags), .strb(strb), .alarmHit(alarmHit)
  );

  bcd_clk_datapath u_dp (
    .clk(clk), .rstN(rstN), .mode12(hourMode12), .wrData(wrData),
    .strb(strb), .flags(flags), .timeQ(timeOut), .dateQ(dateOut),
    .dowQ(dowOut), .leap(leapYear)
  );
endmodule

// File: rtl/bcd_clock_chk.sv
module bcd_clock_chk
  import bcd_clk_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              secTick,
  input logic              ldTime,
  input logic              ldDate,
  input logic              ldDow,
  input logic [DATE_W-1:0] wrData,
  input logic [TIME_W-1:0] timeOut,
  input logic [DATE_W-1:0] dateOut,
  input logic [DOW_W-1:0]  dowOut,
  input logic              alarmHit
);
  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (secTick && !ldTime && timeOut[6:0] == 7'h59) |=> timeOut[6:0] == 7'h00); // R1
  AST_ALARM_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    alarmHit |=> !alarmHit); // R8
  AST_TIME_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    ldTime |=> timeOut == ($past(wrData[TIME_W-1:0]) & TIME_MASK)); // R9
  AST_DATE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    ldDate |=> dateOut == ($past(wrData) & DATE_MASK)); // R9
  AST_TIME_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!secTick && !ldTime) |=> $stable(timeOut)); // R10
  AST_DATE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!secTick && !ldDate) |=> $stable(dateOut)); // R10
  AST_DOW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!secTick && !ldDow) |=> $stable(dowOut)); // R6
endmodule

bind bcd_clock_cal bcd_clock_chk u_chk (.*);

// File: tb/sim_bcd_clock_cal.sv
module sim_bcd_clock_cal;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic secTick = 1'b0, hourMode12 = 1'b0;
  logic ldTime = 1'b0, ldDate = 1'b0, ldDow = 1'b0, ldAlmTime = 1'b0, ldAlmDate = 1'b0;
  logic [23:0] wrData = '0;
  logic [21:0] timeOut;
  logic [23:0] dateOut;
  logic [2:0]  dowOut;
  logic        leapYear, alarmHit;

  int nVec = 0, nBad = 0;
  bit chkOn = 0, done = 0;

  logic [21:0] mT, mAT;
  logic [23:0] mD, mAD;
  logic [2:0]  mDow;
  bit mHit, oldM, cy;

  bcd_clock_cal u0 (
    .clk(clk), .rstN(rstN), .secTick(secTick), .hourMode12(hourMode12),
    .ldTime(ldTime), .ldDate(ldDate), .ldDow(ldDow),
    .ldAlmTime(ldAlmTime), .ldAlmDate(ldAlmDate), .wrData(wrData),
    .timeOut(timeOut), .dateOut(dateOut), .dowOut(dowOut),
    .leapYear(leapYear), .alarmHit(alarmHit)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void advTime(inout logic [21:0] t, input bit m12, output bit carry);
    int s, mi, h, tot;
    bit pm;
    s  = int'(t[6:4]) * 10 + int'(t[3:0]);
    mi = int'(t[14:12]) * 10 + int'(t[11:8]);
    if (m12) begin
      h = int'(t[20]) * 10 + int'(t[19:16]);
      h = (h % 12) + (t[21] ? 12 : 0);
    end else h = int'(t[21:20]) * 10 + int'(t[19:16]);
    tot = h * 3600 + mi * 60 + s + 1;
    carry = (tot >= 86400);
    tot = tot % 86400;
    h = tot / 3600; mi = (tot / 60) % 60; s = tot % 60;
    t = '0;
    t[3:0] = 4'(s % 10);  t[6:4] = 3'(s / 10);
    t[11:8] = 4'(mi % 10); t[14:12] = 3'(mi / 10);
    if (m12) begin
      pm = (h >= 12);
      h = h % 12;
      if (h == 0) h = 12;
      t[21] = pm; t[20] = 1'(h / 10); t[19:16] = 4'(h % 10);
    end else begin
      t[21:20] = 2'(h / 10); t[19:16] = 4'(h % 10);
    end
  endfunction

  function automatic int yearOf(input logic [23:0] d);
    return int'(d[23:20]) * 10 + int'(d[19:16]);
  endfunction

  function automatic void advDate(inout logic [23:0] d);
    int dy, mo, yr, last;
    dy = int'(d[5:4]) * 10 + int'(d[3:0]);
    mo = int'(d[12]) * 10 + int'(d[11:8]);
    yr = yearOf(d);
    case (mo)
      2: last = (yr % 4 == 0) ? 29 : 28;
      4, 6, 9, 11: last = 30;
      default: last = 31;
    endcase
    dy++;
    if (dy > last) begin
      dy = 1; mo++;
      if (mo > 12) begin mo = 1; yr = (yr + 1) % 100; end
    end
    d = '0;
    d[3:0] = 4'(dy % 10); d[5:4] = 2'(dy / 10);
    d[11:8] = 4'(mo % 10); d[12] = 1'(mo / 10);
    d[19:16] = 4'(yr % 10); d[23:20] = 4'(yr / 10);
  endfunction

  // behavioural reference, updated at each rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      mT = '0; mD = 24'h000101; mDow = '0; mAT = '0; mAD = '0; mHit = 0;
    end else begin
      oldM = (mT == mAT) && (mD == mAD);
      cy = 0;
      if (ldTime) mT = wrData[21:0] & 22'h3F7F7F;
      else if (secTick) advTime(mT, hourMode12, cy);
      if (ldDate) mD = wrData & 24'hFF1F3F;
      else if (cy) advDate(mD);
      if (ldDow) mDow = wrData[2:0];
      else if (cy) mDow = (mDow >= 3'd6) ? 3'd0 : mDow + 3'd1;
      if (ldAlmTime) mAT = wrData[21:0] & 22'h3F7F7F;
      if (ldAlmDate) mAD = wrData & 24'hFF1F3F;
      mHit = ((mT == mAT) && (mD == mAD)) && !oldM;
    end
  end

  always @(negedge clk) begin
    if (chkOn && !done) begin
      check("R1 time", 32'(timeOut), 32'(mT));
      check("R4 date", 32'(dateOut), 32'(mD));
      check("R6 dow", 32'(dowOut), 32'(mDow));
      check("R5 leap", 32'(leapYear), 32'(yearOf(mD) % 4 == 0));
      check("R8 alarm", 32'(alarmHit), 32'(mHit));
    end
  end

  task automatic drive(input bit tk, input bit lt, input bit ld, input bit lw,
                       input bit lat, input bit lad, input logic [23:0] d);
    secTick = tk; ldTime = lt; ldDate = ld; ldDow = lw;
    ldAlmTime = lat; ldAlmDate = lad; wrData = d;
    @(negedge clk);
  endtask

  task automatic idle();     drive(0, 0, 0, 0, 0, 0, 24'h0); endtask
  task automatic tick();     drive(1, 0, 0, 0, 0, 0, 24'h0); endtask
  task automatic setTime(input logic [23:0] d); drive(0, 1, 0, 0, 0, 0, d); endtask
  task automatic setDate(input logic [23:0] d); drive(0, 0, 1, 0, 0, 0, d); endtask
  task automatic setDow(input logic [23:0] d);  drive(0, 0, 0, 1, 0, 0, d); endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 reset time", 32'(timeOut), 32'h0);
    check("R10 reset date", 32'(dateOut), 32'h000101);
    check("R10 reset dow", 32'(dowOut), 32'h0);
    check("R10 reset leap", 32'(leapYear), 32'h1);
    check("R10 reset alarm", 32'(alarmHit), 32'h0);
    rstN = 1'b1;
    chkOn = 1;
    idle();
    repeat (3) idle();
    check("R10 hold", 32'(timeOut), 32'h0);
    repeat (70) tick();
    check("R1 count", 32'(timeOut), 32'h000110);

    // R2 and R5: leap February
    setTime(24'h235958); setDate(24'h240228); setDow(24'h6);
    tick(); tick();
    check("R2 midnight", 32'(timeOut), 32'h0);
    check("R5 feb29", 32'(dateOut), 32'h240229);
    check("R6 wrap", 32'(dowOut), 32'h0);
    // R5 non-leap
    setTime(24'h235959); setDate(24'h230228); tick();
    check("R5 mar1", 32'(dateOut), 32'h230301);
    check("R5 noleap", 32'(leapYear), 32'h0);
    // R4 thirty-day month
    setTime(24'h235959); setDate(24'h230430); tick();
    check("R4 may1", 32'(dateOut), 32'h230501);
    // R7 year end
    setTime(24'h235959); setDate(24'h991231); tick();
    check("R7 newyear", 32'(dateOut), 32'h000101);

    // R3 twelve-hour scale
    hourMode12 = 1'b1;
    setTime(24'h115959); tick();
    check("R3 noon", 32'(timeOut), 32'h320000);
    setTime(24'h325959); tick();
    check("R3 one pm", 32'(timeOut), 32'h210000);
    setTime(24'h315959); setDate(24'h230115); tick();
    check("R3 midnight", 32'(timeOut), 32'h120000);
    check("R3 day step", 32'(dateOut), 32'h230116);

    // R8 alarm
    hourMode12 = 1'b0;
    drive(0, 0, 0, 0, 1, 1, 24'h230116);
    drive(0, 0, 0, 0, 1, 0, 24'h000010);
    setTime(24'h000005);
    repeat (5) tick();
    check("R8 hit", 32'(alarmHit), 32'h1);
    tick();
    check("R8 one cycle", 32'(alarmHit), 32'h0);
    drive(0, 0, 0, 0, 0, 1, 24'h230117);
    setTime(24'h000005);
    repeat (5) tick();
    check("R8 date differs", 32'(alarmHit), 32'h0);

    // R9 loads against ticks
    setTime(24'h235959); setDow(24'h3);
    drive(1, 1, 0, 0, 0, 0, 24'h101010);
    check("R9 time wins", 32'(timeOut), 32'h101010);
    check("R9 date kept", 32'(dateOut), 32'h230116);
    setTime(24'h235959);
    drive(1, 0, 1, 0, 0, 0, 24'h250615);
    check("R9 date wins", 32'(dateOut), 32'h250615);
    check("R9 time rolls", 32'(timeOut), 32'h0);
    check("R9 dow steps", 32'(dowOut), 32'h4);
    setTime(24'h235959);
    drive(1, 0, 0, 1, 0, 0, 24'h000002);
    check("R9 dow wins", 32'(dowOut), 32'h2);
    setTime(24'hFFFFFF);
    check("R9 mask", 32'(timeOut), 32'h3F7F7F);

    // long mixed run through many days
    setDate(24'h960101); setDow(24'h0);
    for (int i = 0; i < 3000; i++) begin
      hourMode12 = (i % 7 == 3);
      if (i % 97 == 0) begin
        drive(0, 0, 0, 0, 1, 0, hourMode12 ? 24'h315958 : 24'h235958);
        drive(0, 0, 0, 0, 0, 1, mD);
      end
      setTime(hourMode12 ? 24'h315955 : 24'h235955);
      for (int k = 0; k < 7; k++) begin
        drive($urandom_range(0, 3) != 0, 0, (i % 53 == 5 && k == 4),
              (i % 41 == 9 && k == 4), 0, 0, (k == 4) ? 24'h120303 : 24'h0);
      end
    end
    idle();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      nBad++;
      $display("FAIL watchdog R10 act=hung exp=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end
endmodule